// File: doc/BRIEF.md
# Execute-Lane Arithmetic and Logic Unit

This block does the arithmetic and logic work in the execute stage of one issue lane of a 16-bit dual-issue core. Each cycle it takes a 4-bit opcode, two register operands and a short signed offset. A decoder turns the opcode into one-hot unit selects. Those selects steer one result bus from one of these sources: an adder/subtractor, a low-half multiplier, a barrel shifter, a bitwise logic unit or a pass-through move path. Load and store use the same adder to form an address from the first operand and the sign-extended offset.

Compare writes no general result. It raises a flag-write strobe and drives a flag word that the register file stores in register 7, where later conditional branches read it. A second strobe tells writeback whether the result bus goes to a destination register. There is no divide or remainder path, so every operation fits in the same combinational depth. A parameter selects whether the outputs pass through one register stage or leave the block directly. The default is registered.

Top module: `exec_alu`

## Requirements
- R1: While reset is low, and on the first edge after it, result, flags, reg_we and flag_we are all zero.
- R2: Opcode 0001 gives A+B and opcode 0010 gives A−B, both modulo 2^16, with reg_we high.
- R3: Opcode 0011 gives the low 16 bits of the unsigned product A×B, with reg_we high.
- R4: Opcode 1000 gives A|B, opcode 1001 gives A&B and opcode 1010 gives ~A; for 1010 the value of B has no effect.
- R5: Opcode 1011 shifts A left and opcode 1101 shifts A right, by B[3:0] positions with zero fill; B[15:4] has no effect.
- R6: Opcode 0111 passes A to the result unchanged, B has no effect, and reg_we is high.
- R7: Opcodes 0100 and 0101 give A plus the 5-bit offset sign-extended to 16 bits; reg_we is high for 0100 and low for 0101.
- R8: Opcode 0110 sets flags bit 0 when A==B and bit 1 when A>B unsigned, leaves flags bits 15..2 zero, drives result 0, sets flag_we high and reg_we low.
- R9: Opcodes 0000, 1100, 1110 and 1111 drive result 0 with reg_we and flag_we low.
- R10: For every opcode other than 0110, flag_we is low and flags is zero.
- R11: With the output register enabled (the default), the outputs for the inputs present at a rising clock edge appear after that edge, and back-to-back operations do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| opcode | input | 4 | Operation code |
| opa | input | 16 | First operand (A) |
| opb | input | 16 | Second operand (B) |
| imm | input | 5 | Signed address offset for load and store |
| result | output | 16 | Selected unit result or address |
| flags | output | 16 | Compare flag word for register 7 |
| reg_we | output | 1 | Result is to be written to the destination register |
| flag_we | output | 1 | Flag word is to be written to register 7 |

## Verification
The assertions assume that opcode, operands and offset hold defined values at each rising edge once reset is released, and that reset is held low for at least one edge. The bench changes inputs only on falling edges and always uses defined values. It keeps reset asserted for several cycles, during which it applies non-trivial operands so that the zeroed outputs show the reset at work. After the directed corner cases, a pseudo-random sweep cycles through all sixteen opcodes with operands from an LFSR.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_ADD   = 4'h1,
        OP_SUB   = 4'h2,
        OP_MUL   = 4'h3,
        OP_LOAD  = 4'h4,
        OP_STORE = 4'h5,
        OP_CMP   = 4'h6,
        OP_MOV   = 4'h7,
        OP_OR    = 4'h8,
        OP_AND   = 4'h9,
        OP_NOT   = 4'hA,
        OP_LSL   = 4'hB,
        OP_JUMP  = 4'hC,
        OP_LSR   = 4'hD,
        OP_BEQ   = 4'hE,
        OP_BGT   = 4'hF
    } opcode_e;

    // one-hot unit selects plus writeback intent
    typedef struct packed {
        logic is_add;
        logic is_sub;
        logic is_mul;
        logic is_addr;
        logic is_cmp;
        logic is_mov;
        logic is_or;
        logic is_and;
        logic is_not;
        logic is_shl;
        logic is_shr;
        logic wr_reg;
        logic wr_flag;
    } alu_sel_t;

    localparam int FLAG_EQ_BIT = 0;
    localparam int FLAG_GT_BIT = 1;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [3:0] opcode,
    output alu_sel_t   sel
);

    logic [10:0] unit_vec;

    always_comb begin
        sel = '0;
        case (opcode_e'(opcode))
            OP_ADD:   begin sel.is_add  = 1'b1; sel.wr_reg = 1'b1; end
            OP_SUB:   begin sel.is_sub  = 1'b1; sel.wr_reg = 1'b1; end
            OP_MUL:   begin sel.is_mul  = 1'b1; sel.wr_reg = 1'b1; end
            OP_LOAD:  begin sel.is_addr = 1'b1; sel.wr_reg = 1'b1; end
            OP_STORE: begin sel.is_addr = 1'b1; end
            OP_CMP:   begin sel.is_cmp  = 1'b1; sel.wr_flag = 1'b1; end
            OP_MOV:   begin sel.is_mov  = 1'b1; sel.wr_reg = 1'b1; end
            OP_OR:    begin sel.is_or   = 1'b1; sel.wr_reg = 1'b1; end
            OP_AND:   begin sel.is_and  = 1'b1; sel.wr_reg = 1'b1; end
            OP_NOT:   begin sel.is_not  = 1'b1; sel.wr_reg = 1'b1; end
            OP_LSL:   begin sel.is_shl  = 1'b1; sel.wr_reg = 1'b1; end
            OP_LSR:   begin sel.is_shr  = 1'b1; sel.wr_reg = 1'b1; end
            default:  sel = '0;
        endcase
    end

    assign unit_vec = {sel.is_add, sel.is_sub, sel.is_mul, sel.is_addr, sel.is_cmp,
                       sel.is_mov, sel.is_or, sel.is_and, sel.is_not, sel.is_shl,
                       sel.is_shr};

    always_comb begin
        // R9: at most one functional unit is chosen per opcode
        a_r9_onehot_units: assert ($onehot0(unit_vec));
        // R8: compare never requests a register write
        a_r8_cmp_no_reg: assert (!(sel.is_cmp && sel.wr_reg));
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              eq,
    output logic              gt
);

    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
        eq    = (a == b);
        gt    = (a > b);
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] shl_out,
    output logic [DATA_W-1:0] shr_out
);

    logic [DATA_W-1:0] l_lvl [0:AMT_W];
    logic [DATA_W-1:0] r_lvl [0:AMT_W];

    assign l_lvl[0] = a;
    assign r_lvl[0] = a;

    for (genvar s = 0; s < AMT_W; s++) begin : g_lvl
        localparam int STEP = 1 << s;
        assign l_lvl[s+1] = amt[s] ? {l_lvl[s][DATA_W-1-STEP:0], {STEP{1'b0}}} : l_lvl[s];
        assign r_lvl[s+1] = amt[s] ? {{STEP{1'b0}}, r_lvl[s][DATA_W-1:STEP]} : r_lvl[s];
    end

    assign shl_out = l_lvl[AMT_W];
    assign shr_out = r_lvl[AMT_W];

    always_comb begin
        // R5: a zero amount leaves the operand untouched in both directions
        if (amt == '0) begin
            a_r5_zero_shift: assert (shl_out == a && shr_out == a);
        end
        // R5: any nonzero amount fills the vacated end with zero
        if (amt != '0) begin
            a_r5_zero_fill: assert (!shl_out[0] && !shr_out[DATA_W-1]);
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_or,
    input  logic              do_and,
    input  logic              do_not,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        y = '0;
        if (do_or)  y = a | b;
        if (do_and) y = a & b;
        if (do_not) y = ~a;
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IMM_W   = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags,
    output logic              reg_we,
    output logic              flag_we
);

    localparam int AMT_W = $clog2(DATA_W);
    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] flags;
        logic              reg_we;
        logic              flag_we;
    } lane_out_t;

    alu_sel_t          sel;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] sum;
    logic              cmp_eq;
    logic              cmp_gt;
    logic [DATA_W-1:0] mul_lo;
    logic [DATA_W-1:0] shl_out;
    logic [DATA_W-1:0] shr_out;
    logic [DATA_W-1:0] logic_out;
    lane_out_t         out_d;
    lane_out_t         out_q;

    alu_decode u_dec (
        .opcode (opcode),
        .sel    (sel)
    );

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign add_b   = sel.is_addr ? imm_ext : opb;

    alu_addsub #(.DATA_W(DATA_W)) u_add (
        .a   (opa),
        .b   (add_b),
        .sub (sel.is_sub),
        .sum (sum),
        .eq  (cmp_eq),
        .gt  (cmp_gt)
    );

    assign mul_lo = opa * opb;

    alu_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shf (
        .a       (opa),
        .amt     (opb[AMT_W-1:0]),
        .shl_out (shl_out),
        .shr_out (shr_out)
    );

    alu_logic #(.DATA_W(DATA_W)) u_log (
        .a      (opa),
        .b      (opb),
        .do_or  (sel.is_or),
        .do_and (sel.is_and),
        .do_not (sel.is_not),
        .y      (logic_out)
    );

    always_comb begin
        out_d = '0;
        if (sel.is_add || sel.is_sub || sel.is_addr) out_d.result = sum;
        if (sel.is_mul)                              out_d.result = mul_lo;
        if (sel.is_shl)                              out_d.result = shl_out;
        if (sel.is_shr)                              out_d.result = shr_out;
        if (sel.is_or || sel.is_and || sel.is_not)   out_d.result = logic_out;
        if (sel.is_mov)                              out_d.result = opa;
        if (sel.is_cmp) begin
            out_d.flags[FLAG_EQ_BIT] = cmp_eq;
            out_d.flags[FLAG_GT_BIT] = cmp_gt;
        end
        out_d.reg_we  = sel.wr_reg;
        out_d.flag_we = sel.wr_flag;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        // R2: an add lands one edge later as the wrapped sum
        a_r2_add_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (opcode == OP_ADD) |=> (result == $past(opa) + $past(opb)) && reg_we);
        // R9: control-flow and idle opcodes leave nothing to write
        a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
            (opcode == OP_NOP || opcode == OP_JUMP || opcode == OP_BEQ || opcode == OP_BGT)
            |=> (result == '0) && !reg_we && !flag_we);
        // R6: move copies the first operand
        a_r6_move: assert property (@(posedge clk) disable iff (!rst_n)
            (opcode == OP_MOV) |=> (result == $past(opa)));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign result  = out_q.result;
    assign flags   = out_q.flags;
    assign reg_we  = out_q.reg_we;
    assign flag_we = out_q.flag_we;

    // R8: a compare cannot also claim a register write
    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_we && reg_we));
    // R8: equal and greater never hold together
    a_r8_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[FLAG_EQ_BIT] && flags[FLAG_GT_BIT]));
    // R10: the flag word is quiet unless it is being written
    a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |-> (flags == '0));
    // R8: only the two low flag bits may be set
    a_r8_upper_flags: assert property (@(posedge clk) disable iff (!rst_n)
        flags[DATA_W-1:2] == '0);

endmodule

// File: tb/sim_exec_alu.sv
module sim_exec_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = 4'h0;
    logic [15:0] opa = 16'h0;
    logic [15:0] opb = 16'h0;
    logic [4:0]  imm = 5'h0;
    logic [15:0] result;
    logic [15:0] flags;
    logic        reg_we;
    logic        flag_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] res;
        logic [15:0] flg;
        logic        rwe;
        logic        fwe;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    exec_alu u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .opa     (opa),
        .opb     (opb),
        .imm     (imm),
        .result  (result),
        .flags   (flags),
        .reg_we  (reg_we),
        .flag_we (flag_we)
    );

    function automatic exp_t model(input logic [3:0] op, input logic [15:0] a,
                                   input logic [15:0] b, input logic [4:0] im,
                                   input string tag);
        exp_t e;
        logic [15:0] ext;
        ext   = {{11{im[4]}}, im};
        e.tag = tag;
        e.res = 16'h0;
        e.flg = 16'h0;
        e.fwe = 1'b0;
        e.rwe = !(op == 4'h0 || op == 4'h5 || op == 4'h6 || op == 4'hC ||
                  op == 4'hE || op == 4'hF);
        case (op)
            4'h1: e.res = a + b;
            4'h2: e.res = a - b;
            4'h3: begin
                logic [31:0] p;
                p     = {16'h0, a} * {16'h0, b};
                e.res = p[15:0];
            end
            4'h4, 4'h5: e.res = a + ext;
            4'h6: begin
                e.flg[0] = (a == b);
                e.flg[1] = (a > b);
                e.fwe    = 1'b1;
            end
            4'h7: e.res = a;
            4'h8: e.res = a | b;
            4'h9: e.res = a & b;
            4'hA: e.res = ~a;
            4'hB: e.res = a << b[3:0];
            4'hD: e.res = a >> b[3:0];
            default: e.res = 16'h0;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [4:0] im, input string tag);
        @(negedge clk);
        opcode = op;
        opa    = a;
        opb    = b;
        imm    = im;
        sb.push_back(model(op, a, b, im, tag));
    endtask

    // monitor: one registered result per pushed item, read just after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res || flags !== e.flg || reg_we !== e.rwe || flag_we !== e.fwe) begin
                errors++;
                $display("FAIL %s: got res=%h flg=%h rwe=%b fwe=%b, expected res=%h flg=%h rwe=%b fwe=%b",
                         e.tag, result, flags, reg_we, flag_we, e.res, e.flg, e.rwe, e.fwe);
            end
        end
    end

    task automatic check_reset(input string tag);
        checks++;
        if (result !== 16'h0 || flags !== 16'h0 || reg_we !== 1'b0 || flag_we !== 1'b0) begin
            errors++;
            $display("FAIL %s: got res=%h flg=%h rwe=%b fwe=%b, expected all zero",
                     tag, result, flags, reg_we, flag_we);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        // R1: inputs busy while reset is held, outputs must stay zero
        opcode = 4'h6; opa = 16'h1234; opb = 16'h1234;
        repeat (3) @(negedge clk);
        check_reset("R1");
        opcode = 4'h1;
        repeat (2) @(negedge clk);
        check_reset("R1");
        rst_n = 1'b1;

        // R2 add/sub wrap
        drive(4'h1, 16'hFFFF, 16'h0002, 5'h0, "R2");
        drive(4'h2, 16'h0003, 16'h0005, 5'h0, "R2");
        drive(4'h1, 16'h1234, 16'h4321, 5'h0, "R2");
        // R3 multiply low half
        drive(4'h3, 16'h1234, 16'h0100, 5'h0, "R3");
        drive(4'h3, 16'hFFFF, 16'hFFFF, 5'h0, "R3");
        // R4 logic, NOT ignores B
        drive(4'h8, 16'hF0F0, 16'h0FF0, 5'h0, "R4");
        drive(4'h9, 16'hF0F0, 16'h0FF0, 5'h0, "R4");
        drive(4'hA, 16'h00FF, 16'hABCD, 5'h0, "R4");
        // R5 shifts, upper B ignored
        drive(4'hB, 16'h8001, 16'h0000, 5'h0, "R5");
        drive(4'hB, 16'h0001, 16'h000F, 5'h0, "R5");
        drive(4'hB, 16'h0011, 16'hFFF3, 5'h0, "R5");
        drive(4'hD, 16'h8000, 16'h000F, 5'h0, "R5");
        drive(4'hD, 16'hF000, 16'h1234, 5'h0, "R5");
        // R6 move ignores B
        drive(4'h7, 16'hBEEF, 16'h5555, 5'h0, "R6");
        // R7 address with negative and positive offsets
        drive(4'h4, 16'h0100, 16'h7777, 5'b10000, "R7");
        drive(4'h5, 16'h0100, 16'h7777, 5'b01111, "R7");
        drive(4'h4, 16'h0000, 16'h0000, 5'b11111, "R7");
        // R8 compare equal, greater, less, unsigned top bit
        drive(4'h6, 16'h00AA, 16'h00AA, 5'h0, "R8");
        drive(4'h6, 16'h0005, 16'h0003, 5'h0, "R8");
        drive(4'h6, 16'h0003, 16'h0005, 5'h0, "R8");
        drive(4'h6, 16'h8000, 16'h0001, 5'h0, "R8");
        // R9 no-result opcodes with busy operands
        drive(4'h0, 16'hFFFF, 16'hFFFF, 5'h1F, "R9");
        drive(4'hC, 16'h1234, 16'h5678, 5'h0, "R9");
        drive(4'hE, 16'h1111, 16'h1111, 5'h0, "R9");
        drive(4'hF, 16'h9999, 16'h0001, 5'h0, "R9");
        // R10 and R11: back-to-back sweep over every opcode
        lfsr = 16'hACE1;
        for (int i = 0; i < 256; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a    = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b    = (i % 7 == 0) ? a : lfsr;
            drive(4'(i), a, b, lfsr[4:0], (i % 2 == 0) ? "R10" : "R11");
        end
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule